// File: doc/BRIEF.md
# Byte-Lane Swap Unit with Automatic Size Detection

This block reorders the byte lanes of a 32-bit data word on its way between a big-endian local bus and little-endian PCI address space. Each translation path has one instance. A 2-bit mode picks the reordering:

- plain pass-through;
- exchange of the two 16-bit halves;
- reversal of all four bytes;
- an automatic setting that infers the transfer size from the active-low byte enables and chooses the matching swap.

The automatic setting is only meaningful for single-size accesses, so it is refused on DMA transfers. When a DMA transfer requests it, the block passes the word unchanged and flags an error for that result. The reordered word, a valid flag, the mode actually applied and the error flag are all registered, so every result appears one clock after the input. The applied mode lets the automatic decision be observed.

Top module: `bswap_unit`

## Requirements
- R1: A synchronous active-high reset clears out_valid, out_data, out_mode and out_err to zero.
- R2: out_valid equals in_valid delayed by exactly one clock. out_data, out_mode and out_err for an accepted word appear in that same cycle.
- R3: Mode 2'b00 passes the word unchanged and reports out_mode 2'b00.
- R4: Mode 2'b01 swaps halves. Output bits [31:16] take input bits [15:0], output bits [15:0] take input bits [31:16], and out_mode is 2'b01.
- R5: Mode 2'b10 reverses bytes. Output byte k (bits 8k+7:8k) takes input byte 3-k, and out_mode is 2'b10.
- R6: In mode 2'b11 without DMA, in_be_n equal to 4'b1100 or 4'b0011 applies the R4 half swap and reports out_mode 2'b01.
- R7: In mode 2'b11 without DMA, an in_be_n with exactly one zero bit (4'b1110, 4'b1101, 4'b1011, 4'b0111) applies the R5 byte reversal and reports out_mode 2'b10.
- R8: In mode 2'b11 without DMA, every other in_be_n value passes the word unchanged and reports out_mode 2'b00.
- R9: Mode 2'b11 with in_dma high passes the word unchanged, reports out_mode 2'b00 and raises out_err for that result.
- R10: out_err is low for any result that is not an automatic request made with in_dma high. Modes 00, 01 and 10 behave the same whatever the value of in_dma.
- R11: In a cycle with in_valid low, out_data and out_mode keep their previous values, and out_valid and out_err go low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word present |
| in_data | input | 32 | Input word |
| in_be_n | input | 4 | Active-low byte enables, bit k for byte k |
| in_mode | input | 2 | Requested swap mode |
| in_dma | input | 1 | Transfer belongs to a DMA channel |
| out_valid | output | 1 | Registered result present |
| out_data | output | 32 | Reordered word |
| out_mode | output | 2 | Swap mode actually applied |
| out_err | output | 1 | Automatic mode refused for DMA |

## Verification
Every result of this block (word, valid flag, applied mode and error flag) is due exactly one clock edge after the input is presented. The bench therefore drives each input on a falling edge and compares all four outputs one time unit after the next rising edge. It does this before the following input is driven, so each comparison belongs to one stimulus. For the hold behaviour, an idle cycle carrying different data is compared at that same point against the word from the previous accepted cycle.

// File: rtl/bswap_pkg.sv
package bswap_pkg;

    typedef enum logic [1:0] {
        SW_PASS = 2'b00,
        SW_HALF = 2'b01,
        SW_BYTE = 2'b10,
        SW_AUTO = 2'b11
    } swap_mode_e;

    typedef struct packed {
        swap_mode_e mode;
        logic       err;
    } swap_sel_t;

    function automatic swap_sel_t sel_make(input swap_mode_e m, input logic e);
        swap_sel_t s;
        s.mode = m;
        s.err  = e;
        return s;
    endfunction

endpackage

// File: rtl/bswap_auto_decode.sv
module bswap_auto_decode
    import bswap_pkg::*;
#(
    parameter int LANES = 4
) (
    input  swap_mode_e         req,
    input  logic [LANES-1:0]   be_n,
    input  logic               dma,
    output swap_sel_t          sel
);
    localparam int HALF  = LANES / 2;
    localparam int CNT_W = $clog2(LANES + 1);

    logic [CNT_W-1:0] n_active;
    logic             half_pat;
    logic             single_pat;

    always_comb begin
        n_active = '0;
        for (int k = 0; k < LANES; k++) begin
            n_active = n_active + CNT_W'(!be_n[k]);
        end
    end

    assign half_pat   = (be_n == {{HALF{1'b1}}, {HALF{1'b0}}}) ||
                        (be_n == {{HALF{1'b0}}, {HALF{1'b1}}});
    assign single_pat = (n_active == CNT_W'(1));

    always_comb begin
        if (req != SW_AUTO) begin
            sel = sel_make(req, 1'b0);
        end else if (dma) begin
            sel = sel_make(SW_PASS, 1'b1);
        end else if (half_pat) begin
            sel = sel_make(SW_HALF, 1'b0);
        end else if (single_pat) begin
            sel = sel_make(SW_BYTE, 1'b0);
        end else begin
            sel = sel_make(SW_PASS, 1'b0);
        end
    end

endmodule

// File: rtl/bswap_lane_mux.sv
module bswap_lane_mux
    import bswap_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int LANES  = 4
) (
    input  swap_mode_e                 mode,
    input  logic [BYTE_W*LANES-1:0]    din,
    output logic [BYTE_W*LANES-1:0]    dout
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam int SRC_HALF = i ^ (LANES / 2);
        localparam int SRC_REV  = LANES - 1 - i;
        always_comb begin
            unique case (mode)
                SW_HALF: dout[i*BYTE_W +: BYTE_W] = din[SRC_HALF*BYTE_W +: BYTE_W];
                SW_BYTE: dout[i*BYTE_W +: BYTE_W] = din[SRC_REV*BYTE_W +: BYTE_W];
                default: dout[i*BYTE_W +: BYTE_W] = din[i*BYTE_W +: BYTE_W];
            endcase
        end
    end

endmodule

// File: rtl/bswap_unit.sv
module bswap_unit
    import bswap_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int LANES  = 4,
    localparam int DATA_W = BYTE_W * LANES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic [LANES-1:0]  in_be_n,
    input  logic [1:0]        in_mode,
    input  logic              in_dma,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic [1:0]        out_mode,
    output logic              out_err
);
    swap_sel_t         sel;
    logic [DATA_W-1:0] swapped;

    bswap_auto_decode #(.LANES(LANES)) i_decode (
        .req  (swap_mode_e'(in_mode)),
        .be_n (in_be_n),
        .dma  (in_dma),
        .sel  (sel)
    );

    bswap_lane_mux #(.BYTE_W(BYTE_W), .LANES(LANES)) i_mux (
        .mode (sel.mode),
        .din  (in_data),
        .dout (swapped)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_mode  <= SW_PASS;
            out_err   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            out_err   <= in_valid && sel.err;
            if (in_valid) begin
                out_data <= swapped;
                out_mode <= sel.mode;
            end
        end
    end

    // R2: valid follows input by one clock
    p_valid_delay_r2: assert property (@(posedge clk) disable iff (rst)
        out_valid == $past(in_valid));

    // R9: automatic request on DMA is refused, data passes, error raised
    p_dma_auto_refused_r9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_mode == 2'b11 && in_dma) |=>
            (out_err && out_mode == 2'b00 && out_data == $past(in_data)));

    // R10: no error unless automatic mode was requested on DMA
    p_err_only_auto_dma_r10: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && in_mode == 2'b11 && in_dma) |=> !out_err);

    // R11: idle cycles hold the word and the applied mode
    p_idle_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_data) && $stable(out_mode)));

    // R5: byte reversal moves the top input byte to the bottom lane
    p_rev_low_byte_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_mode == 2'b10) |=>
            (out_data[BYTE_W-1:0] == $past(in_data[DATA_W-1 -: BYTE_W])));

    // R3: pass mode leaves the word untouched
    p_pass_through_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_mode == 2'b00) |=> (out_data == $past(in_data) && out_mode == 2'b00));

endmodule

// File: tb/test_bswap_unit.sv
module test_bswap_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic [3:0]  in_be_n = 4'hF;
    logic [1:0]  in_mode = 2'b00;
    logic        in_dma = 1'b0;
    logic        out_valid;
    logic [31:0] out_data;
    logic [1:0]  out_mode;
    logic        out_err;

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] last_data = '0;
    logic [1:0]  last_mode = '0;

    always #5 clk = ~clk;

    bswap_unit i_bswap_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_be_n(in_be_n), .in_mode(in_mode), .in_dma(in_dma),
        .out_valid(out_valid), .out_data(out_data), .out_mode(out_mode),
        .out_err(out_err)
    );

    function automatic logic [1:0] exp_mode(input logic [1:0] m, input logic [3:0] be, input logic dma);
        if (m != 2'b11) return m;
        if (dma) return 2'b00;
        if (be == 4'b1100 || be == 4'b0011) return 2'b01;
        if (be == 4'b1110 || be == 4'b1101 || be == 4'b1011 || be == 4'b0111) return 2'b10;
        return 2'b00;
    endfunction

    function automatic logic [31:0] exp_data(input logic [31:0] d, input logic [1:0] em);
        case (em)
            2'b01:   return {d[15:0], d[31:16]};
            2'b10:   return {d[7:0], d[15:8], d[23:16], d[31:24]};
            default: return d;
        endcase
    endfunction

    function automatic string tag_of(input logic [1:0] m, input logic [3:0] be, input logic dma);
        if (m == 2'b00) return "R3";
        if (m == 2'b01) return "R4";
        if (m == 2'b10) return "R5";
        if (dma) return "R9";
        case (exp_mode(m, be, dma))
            2'b01:   return "R6";
            2'b10:   return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic xfer(input logic [31:0] d, input logic [3:0] be, input logic [1:0] m, input logic dma);
        logic [1:0] em;
        string t;
        em = exp_mode(m, be, dma);
        t = tag_of(m, be, dma);
        @(negedge clk);
        in_valid = 1'b1; in_data = d; in_be_n = be; in_mode = m; in_dma = dma;
        @(posedge clk); #1;
        check("R2", "out_valid", {31'd0, out_valid}, 32'd1);
        check(t, "out_data", out_data, exp_data(d, em));
        check(t, "out_mode", {30'd0, out_mode}, {30'd0, em});
        check((m == 2'b11 && dma) ? "R9" : "R10", "out_err", {31'd0, out_err},
              {31'd0, (m == 2'b11 && dma)});
        last_data = exp_data(d, em);
        last_mode = em;
    endtask

    task automatic idle(input logic [31:0] d);
        @(negedge clk);
        in_valid = 1'b0; in_data = d; in_mode = 2'b11; in_dma = 1'b1; in_be_n = 4'b1110;
        @(posedge clk); #1;
        check("R11", "out_valid idle", {31'd0, out_valid}, 32'd0);
        check("R11", "out_data hold", out_data, last_data);
        check("R11", "out_mode hold", {30'd0, out_mode}, {30'd0, last_mode});
        check("R11", "out_err idle", {31'd0, out_err}, 32'd0);
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1;
        check("R1", "out_valid reset", {31'd0, out_valid}, 32'd0);
        check("R1", "out_data reset", out_data, 32'd0);
        check("R1", "out_mode reset", {30'd0, out_mode}, 32'd0);
        check("R1", "out_err reset", {31'd0, out_err}, 32'd0);
        @(negedge clk);
        rst = 1'b0;

        xfer(32'h11223344, 4'b0000, 2'b00, 1'b0);   // R3
        xfer(32'h11223344, 4'b0000, 2'b01, 1'b0);   // R4
        xfer(32'h11223344, 4'b0000, 2'b10, 1'b0);   // R5
        xfer(32'hA1B2C3D4, 4'b1100, 2'b11, 1'b0);   // R6
        xfer(32'hA1B2C3D4, 4'b0011, 2'b11, 1'b0);   // R6
        xfer(32'hA1B2C3D4, 4'b1110, 2'b11, 1'b0);   // R7
        xfer(32'hA1B2C3D4, 4'b1101, 2'b11, 1'b0);   // R7
        xfer(32'hA1B2C3D4, 4'b1011, 2'b11, 1'b0);   // R7
        xfer(32'hA1B2C3D4, 4'b0111, 2'b11, 1'b0);   // R7
        xfer(32'hA1B2C3D4, 4'b0000, 2'b11, 1'b0);   // R8
        xfer(32'hA1B2C3D4, 4'b1010, 2'b11, 1'b0);   // R8
        xfer(32'hA1B2C3D4, 4'b1111, 2'b11, 1'b0);   // R8
        xfer(32'hA1B2C3D4, 4'b1100, 2'b11, 1'b1);   // R9
        idle(32'hDEADBEEF);                          // R11
        xfer(32'h0F1E2D3C, 4'b1110, 2'b01, 1'b1);   // R10
        xfer(32'h0F1E2D3C, 4'b1110, 2'b10, 1'b1);   // R10
        idle(32'h55AA55AA);                          // R11

        for (int n = 0; n < 400; n++) begin
            logic [31:0] rd;
            logic [3:0]  rb;
            logic [1:0]  rm;
            logic        rdma;
            rd = $urandom; rb = 4'($urandom); rm = 2'($urandom); rdma = 1'($urandom);
            if (($urandom % 8) == 0) idle($urandom);
            else xfer(rd, rb, rm, rdma);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule